// File: doc/BRIEF.md
# Asynchronous Memory Strobe Controller

This block runs single read and write cycles on an external asynchronous memory or peripheral. A request arrives on a plain request/acknowledge port. The controller then drives one of three chip-select lines low and walks through three phases, each lasting a programmed number of clock cycles: setup, strobe and hold. During the strobe phase it pulls the output-enable line low for a read or the write-enable line low for a write. Address, byte enables and write data come from the request. They are registered when the request is accepted and stay fixed until the cycle ends. Read data is taken from the memory bus on the final strobe cycle and returned together with the acknowledge.

Each region has its own timing word, with separate setup, strobe and hold lengths for reads and for writes. It also has a switch that lets a slow device stretch the strobe phase through a wait input. That input is synchronised before use and its active level is programmable. The device holds the strobe open for as long as it keeps wait active. When wait is released, the cycle finishes with one final strobe cycle. A shared extension limit caps the stretch. When the limit is reached, the controller moves to hold, sets a sticky timeout flag and, if enabled, raises an interrupt.

Configuration map, with the default field width of 4 and extension width of 8:
- Words 0 to 2 hold the timing word of regions 0 to 2:
  - bits [3:0] read setup, [7:4] read strobe, [11:8] read hold;
  - bits [15:12] write setup, [19:16] write strobe, [23:20] write hold;
  - bit 24 enables stretching.
- Word 3 holds the wait settings: bits [7:0] are the extension limit, bit 8 the wait polarity and bit 9 the interrupt enable.
- Word 4 holds the timeout flag in bit 0. Writing 1 to that bit clears it.

The field positions scale with the field-width and extension-width parameters.

Top module: `asm_strobe_ctrl`

## Requirements
- R1: A phase field value F gives F+1 cycles. For every access, chip select is low for setup+strobe+hold cycles, and the strobe line is low only for the middle strobe cycles. A read uses the read fields and drives only output enable. A write uses the write fields and drives only write enable.
- R2: Only the chip-select bit equal to the request's region index goes low, and at most one bit is ever low.
- R3: When a region's stretch-enable bit is 0, the wait input has no effect, and the strobe lasts exactly its programmed length.
- R4: Wait is recognised only when the setup cycles plus the strobe cycles exceed 4. This is evaluated with the fields of the access direction. At 4 or fewer cycles, the wait input has no effect.
- R5: Wait is sampled on the last programmed strobe cycle. If it is active, the strobe is held open. When the pin is released, the strobe ends 3 cycles after the cycle in which the release happened: two synchroniser stages plus one final strobe cycle. The timeout flag is not set.
- R6: Suppose wait stays active and the extension limit is M. The strobe then lasts its programmed length plus M+1 cycles, hold follows, and the timeout flag is set.
- R7: The polarity bit resets to 1, and then a high wait pin is active. When the bit is 0, a low wait pin is active and a high pin is inactive.
- R8: The interrupt output equals the timeout flag ANDed with the interrupt enable, one cycle later. Writing 1 to status bit 0 clears the flag.
- R9: Address, byte enables and write data stay constant while chip select is low. The write-data drive enable is high for the whole of a write and low for a read.
- R10: The acknowledge is a single-cycle pulse in the first cycle after the last hold cycle. At that point chip select is already high. With the acknowledge, the read data equals the memory bus value sampled on the final strobe cycle.
- R11: The extension count restarts for every access. Two back-to-back timed-out accesses have equal strobe lengths.
- R12: After reset, all region words read 0, word 3 reads with only the polarity bit set, and the status reads 0. All chip selects and strobes are high, and the acknowledge and interrupt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CA_W | Configuration word index |
| cfg_wdata | input | CFG_W | Configuration write data |
| cfg_rdata | output | CFG_W | Configuration read data for cfg_addr |
| irq | output | 1 | Timeout interrupt |
| req_valid | input | 1 | Access request, held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | RG_W | Region index 0..N_REGION-1 |
| req_addr | input | ADDR_W | Access address |
| req_be | input | BE_W | Byte enables |
| req_wdata | input | DATA_W | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | DATA_W | Read data, valid with req_ack |
| mem_cs_n | output | N_REGION | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_be | output | BE_W | Memory byte enables |
| mem_wdata | output | DATA_W | Memory write data |
| mem_wdata_oe | output | 1 | Write data drive enable |
| mem_rdata | input | DATA_W | Memory read data |
| mem_wait | input | 1 | Wait input from the device |

## Verification
The bench builds the block with a 4-bit extension limit and an 8-bit address, so that every limit value from 0 to 3 and a whole range of release points can be driven in a few hundred cycles each. It sweeps all setup and strobe fields from 0 to 3 and all hold fields from 0 to 2, for both directions, with the opposite direction's fields set to different values. Each phase length is counted at the pins and compared against field+1. The threshold case is tested on both sides: exactly 4 cycles and exactly 5 cycles. Timeout and release lengths are computed from the limit field and the release cycle.

// File: rtl/asm_pkg.sv
package asm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_EXTEND = 3'd3,
    PH_HOLD   = 3'd4
  } phase_t;

  // six timing fields per region word plus one stretch-enable bit
  localparam int N_TIMING_FIELDS = 6;

  function automatic int rgn_width(input int ph_w);
    return N_TIMING_FIELDS * ph_w + 1;
  endfunction

endpackage

// File: rtl/asm_cfg_regs.sv
module asm_cfg_regs
  import asm_pkg::*;
#(
  parameter int N_REGION = 3,
  parameter int PH_W     = 4,
  parameter int EXT_W    = 8,
  parameter int CFG_W    = 32,
  parameter int CA_W     = 3
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 cfg_we,
  input  logic [CA_W-1:0]                      cfg_addr,
  input  logic [CFG_W-1:0]                     cfg_wdata,
  output logic [CFG_W-1:0]                     cfg_rdata,
  input  logic                                 timeout_set,
  output logic [N_REGION-1:0][rgn_width(PH_W)-1:0] region_cfg,
  output logic [EXT_W-1:0]                     max_ext,
  output logic                                 wait_pol,
  output logic                                 irq
);

  localparam int RGN_W = rgn_width(PH_W);
  localparam logic [CA_W-1:0] A_WAIT = CA_W'(N_REGION);
  localparam logic [CA_W-1:0] A_STAT = CA_W'(N_REGION + 1);

  logic [N_REGION-1:0][RGN_W-1:0] rgn_q;
  logic [EXT_W-1:0] max_q;
  logic             pol_q;
  logic             ien_q;
  logic             flag_q;
  logic             irq_q;

  // one timing word per region
  for (genvar g = 0; g < N_REGION; g++) begin : g_rgn
    always_ff @(posedge clk) begin
      if (rst) begin
        rgn_q[g] <= '0;
      end else if (cfg_we && cfg_addr == CA_W'(g)) begin
        rgn_q[g] <= cfg_wdata[RGN_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      max_q <= '0;
      pol_q <= 1'b1;
      ien_q <= 1'b0;
    end else if (cfg_we && cfg_addr == A_WAIT) begin
      max_q <= cfg_wdata[EXT_W-1:0];
      pol_q <= cfg_wdata[EXT_W];
      ien_q <= cfg_wdata[EXT_W+1];
    end
  end

  // sticky timeout flag: a new timeout wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (timeout_set) begin
        flag_q <= 1'b1;
      end else if (cfg_we && cfg_addr == A_STAT && cfg_wdata[0]) begin
        flag_q <= 1'b0;
      end
      irq_q <= flag_q & ien_q;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < N_REGION; i++) begin
      if (cfg_addr == CA_W'(i)) cfg_rdata = CFG_W'(rgn_q[i]);
    end
    if (cfg_addr == A_WAIT) cfg_rdata = CFG_W'({ien_q, pol_q, max_q});
    if (cfg_addr == A_STAT) cfg_rdata = CFG_W'(flag_q);
  end

  assign region_cfg = rgn_q;
  assign max_ext    = max_q;
  assign wait_pol   = pol_q;
  assign irq        = irq_q;

  p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
    timeout_set |=> flag_q);

  p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == A_STAT && cfg_wdata[0] && !timeout_set) |=> !flag_q);

  p_irq_follow_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_q && ien_q) |=> irq);

endmodule

// File: rtl/asm_wait_sync.sv
module asm_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wait_pin,
  input  logic pol,
  output logic wait_active
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-2:0], wait_pin};
  end

  // polarity 1: high means wait; polarity 0: low means wait
  assign wait_active = pol ? sh_q[STAGES-1] : ~sh_q[STAGES-1];

endmodule

// File: rtl/asm_seq.sv
module asm_seq
  import asm_pkg::*;
#(
  parameter int N_REGION = 3,
  parameter int RG_W     = 2,
  parameter int PH_W     = 4,
  parameter int EXT_W    = 8,
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 16,
  parameter int BE_W     = 2
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     req_valid,
  input  logic                                     req_write,
  input  logic [RG_W-1:0]                          req_region,
  input  logic [ADDR_W-1:0]                        req_addr,
  input  logic [BE_W-1:0]                          req_be,
  input  logic [DATA_W-1:0]                        req_wdata,
  output logic                                     req_ack,
  output logic [DATA_W-1:0]                        req_rdata,
  input  logic [N_REGION-1:0][rgn_width(PH_W)-1:0] region_cfg,
  input  logic [EXT_W-1:0]                         max_ext,
  input  logic                                     wait_active,
  output logic                                     timeout_set,
  output logic [N_REGION-1:0]                      mem_cs_n,
  output logic                                     mem_oe_n,
  output logic                                     mem_we_n,
  output logic [ADDR_W-1:0]                        mem_addr,
  output logic [BE_W-1:0]                          mem_be,
  output logic [DATA_W-1:0]                        mem_wdata,
  output logic                                     mem_wdata_oe,
  input  logic [DATA_W-1:0]                        mem_rdata
);

  localparam int RGN_W = rgn_width(PH_W);
  localparam int O_RS  = 0;
  localparam int O_RT  = PH_W;
  localparam int O_RH  = 2 * PH_W;
  localparam int O_WS  = 3 * PH_W;
  localparam int O_WT  = 4 * PH_W;
  localparam int O_WH  = 5 * PH_W;
  localparam int O_EN  = 6 * PH_W;

  phase_t            phase_q, phase_d;
  logic [PH_W-1:0]   cnt_q, cnt_d;
  logic [EXT_W-1:0]  ext_q, ext_d;
  logic              resumed_q, resumed_d;
  logic              wr_q, wr_d;
  logic [RG_W-1:0]   rg_q, rg_d;
  logic              start, capture, done, tmo;

  logic [RGN_W-1:0]  sel;
  logic [PH_W-1:0]   setup_f, strobe_f, hold_f;
  logic              allowed, wait_eff;
  logic              busy_d, strobe_d;

  // timing word of the active region, fields of the active direction
  always_comb begin
    sel = '0;
    for (int i = 0; i < N_REGION; i++) begin
      if (rg_q == RG_W'(i)) sel = region_cfg[i];
    end
    setup_f  = wr_q ? sel[O_WS +: PH_W] : sel[O_RS +: PH_W];
    strobe_f = wr_q ? sel[O_WT +: PH_W] : sel[O_RT +: PH_W];
    hold_f   = wr_q ? sel[O_WH +: PH_W] : sel[O_RH +: PH_W];
    // cycles = field+1 each, so (fs+1)+(ft+1) > 4  <=>  fs+ft > 2
    allowed  = sel[O_EN] &&
               (({1'b0, setup_f} + {1'b0, strobe_f}) > (PH_W+1)'(2));
  end

  assign wait_eff = wait_active && allowed;

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    ext_d     = ext_q;
    resumed_d = resumed_q;
    start     = 1'b0;
    capture   = 1'b0;
    done      = 1'b0;
    tmo       = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid && !req_ack) begin
          start     = 1'b1;
          phase_d   = PH_SETUP;
          cnt_d     = '0;
          ext_d     = '0;
          resumed_d = 1'b0;
        end
      end
      PH_SETUP: begin
        if (cnt_q == setup_f) begin
          phase_d = PH_STROBE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_STROBE: begin
        if (cnt_q == strobe_f) begin
          if (wait_eff && !resumed_q) begin
            phase_d = PH_EXTEND;
          end else begin
            phase_d = PH_HOLD;
            cnt_d   = '0;
            capture = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_EXTEND: begin
        if (!wait_eff) begin
          // back to the last programmed strobe cycle (cnt still at strobe_f)
          phase_d   = PH_STROBE;
          resumed_d = 1'b1;
        end else if (ext_q == max_ext) begin
          phase_d = PH_HOLD;
          cnt_d   = '0;
          capture = 1'b1;
          tmo     = 1'b1;
        end else begin
          ext_d = ext_q + 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_q == hold_f) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
          done    = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  assign wr_d     = start ? req_write  : wr_q;
  assign rg_d     = start ? req_region : rg_q;
  assign busy_d   = (phase_d != PH_IDLE);
  assign strobe_d = (phase_d == PH_STROBE) || (phase_d == PH_EXTEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q      <= PH_IDLE;
      cnt_q        <= '0;
      ext_q        <= '0;
      resumed_q    <= 1'b0;
      wr_q         <= 1'b0;
      rg_q         <= '0;
      req_ack      <= 1'b0;
      req_rdata    <= '0;
      timeout_set  <= 1'b0;
      mem_oe_n     <= 1'b1;
      mem_we_n     <= 1'b1;
      mem_addr     <= '0;
      mem_be       <= '0;
      mem_wdata    <= '0;
      mem_wdata_oe <= 1'b0;
    end else begin
      phase_q      <= phase_d;
      cnt_q        <= cnt_d;
      ext_q        <= ext_d;
      resumed_q    <= resumed_d;
      wr_q         <= wr_d;
      rg_q         <= rg_d;
      req_ack      <= done;
      timeout_set  <= tmo;
      mem_oe_n     <= !(strobe_d && !wr_d);
      mem_we_n     <= !(strobe_d && wr_d);
      mem_wdata_oe <= busy_d && wr_d;
      if (start) begin
        mem_addr  <= req_addr;
        mem_be    <= req_be;
        mem_wdata <= req_wdata;
      end
      if (capture && !wr_q) req_rdata <= mem_rdata;
    end
  end

  for (genvar g = 0; g < N_REGION; g++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst) mem_cs_n[g] <= 1'b1;
      else     mem_cs_n[g] <= !(busy_d && rg_d == RG_W'(g));
    end
  end

  p_one_region_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n));

  p_strobe_in_select_r1: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n || !mem_we_n) |-> !(&mem_cs_n));

  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  p_ack_single_r10: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(&mem_cs_n) |=> ((&mem_cs_n) || $stable(mem_addr)));

  p_ext_cap_r6: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_EXTEND) |-> (ext_q <= max_ext));

  p_wait_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_STROBE && !allowed) |=> (phase_q != PH_EXTEND));

endmodule

// File: rtl/asm_strobe_ctrl.sv
module asm_strobe_ctrl
  import asm_pkg::*;
#(
  parameter int N_REGION    = 3,
  parameter int PH_W        = 4,
  parameter int EXT_W       = 8,
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int CFG_W       = 32,
  parameter int SYNC_STAGES = 2,
  localparam int BE_W       = DATA_W / 8,
  localparam int RG_W       = (N_REGION > 1) ? $clog2(N_REGION) : 1,
  localparam int CA_W       = $clog2(N_REGION + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [CA_W-1:0]     cfg_addr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [CFG_W-1:0]    cfg_rdata,
  output logic                irq,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [RG_W-1:0]     req_region,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [BE_W-1:0]     req_be,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                req_ack,
  output logic [DATA_W-1:0]   req_rdata,
  output logic [N_REGION-1:0] mem_cs_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [BE_W-1:0]     mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_wdata_oe,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                mem_wait
);

  localparam int RGN_W = rgn_width(PH_W);

  logic [N_REGION-1:0][RGN_W-1:0] region_cfg;
  logic [EXT_W-1:0] max_ext;
  logic             wait_pol;
  logic             wait_active;
  logic             timeout_set;

  asm_cfg_regs #(
    .N_REGION(N_REGION), .PH_W(PH_W), .EXT_W(EXT_W),
    .CFG_W(CFG_W), .CA_W(CA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .timeout_set(timeout_set),
    .region_cfg(region_cfg), .max_ext(max_ext), .wait_pol(wait_pol), .irq(irq)
  );

  asm_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .wait_pin(mem_wait), .pol(wait_pol),
    .wait_active(wait_active)
  );

  asm_seq #(
    .N_REGION(N_REGION), .RG_W(RG_W), .PH_W(PH_W), .EXT_W(EXT_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_region(req_region),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_ack(req_ack), .req_rdata(req_rdata),
    .region_cfg(region_cfg), .max_ext(max_ext), .wait_active(wait_active),
    .timeout_set(timeout_set),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata)
  );

endmodule

// File: tb/tb_asm_strobe_ctrl.sv
module tb_asm_strobe_ctrl;

  localparam int NR = 3;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int EW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          irq;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [1:0]    req_region = '0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_be = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ack;
  logic [DW-1:0] req_rdata;
  logic [NR-1:0] mem_cs_n;
  logic          mem_oe_n, mem_we_n;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_be;
  logic [DW-1:0] mem_wdata;
  logic          mem_wdata_oe;
  logic [DW-1:0] mem_rdata;
  logic          mem_wait = 1'b0;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  // memory model: read data is a fixed function of the address
  function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
    return {a ^ 8'hA5, a};
  endfunction
  assign mem_rdata = mem_fn(mem_addr);

  asm_strobe_ctrl #(
    .N_REGION(NR), .PH_W(4), .EXT_W(EW), .ADDR_W(AW), .DATA_W(DW),
    .CFG_W(32), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .req_valid(req_valid), .req_write(req_write), .req_region(req_region),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_ack(req_ack), .req_rdata(req_rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_wdata_oe(mem_wdata_oe), .mem_rdata(mem_rdata), .mem_wait(mem_wait)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rgn_word(input int rs, rt, rh, ws, wt, wh, input bit en);
    return {7'd0, en, 4'(wh), 4'(wt), 4'(ws), 4'(rh), 4'(rt), 4'(rs)};
  endfunction

  function automatic logic [31:0] wcfg_word(input int mx, input bit pol, input bit ien);
    return {26'd0, ien, pol, 4'(mx)};
  endfunction

  task automatic cfg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input int a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = 3'(a);
    #1 d = cfg_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // runs one access, counts phases at the pins
  task automatic run_acc(input bit w, input int rg, input logic [AW-1:0] adr,
                         input logic [1:0] be, input logic [DW-1:0] wd,
                         input int relk, input bit inact_lvl,
                         output int ns, output int nst, output int nh,
                         output logic [DW-1:0] rd, output int errs);
    bit got = 0;
    bit stb, oth;
    ns = 0; nst = 0; nh = 0; rd = '0; errs = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_region = 2'(rg);
    req_addr = adr; req_be = be; req_wdata = wd;
    for (int c = 0; c < 400 && !got; c++) begin
      @(negedge clk);
      if (req_ack) begin
        rd = req_rdata; got = 1;
        if (mem_cs_n !== 3'b111) errs++;
      end else if (mem_cs_n !== ~(3'b001 << rg)) begin
        errs++;
      end else begin
        stb = w ? !mem_we_n : !mem_oe_n;
        oth = w ? !mem_oe_n : !mem_we_n;
        if (oth) errs++;
        if (stb) nst++;
        else if (nst == 0) ns++;
        else nh++;
        if (mem_addr !== adr || mem_be !== be || mem_wdata_oe !== w) errs++;
        if (w && mem_wdata !== wd) errs++;
        if (relk != 0 && stb && nst == relk) mem_wait = inact_lvl;
      end
    end
    req_valid = 1'b0;
    if (!got) errs++;
    @(negedge clk);
    if (req_ack || mem_cs_n !== 3'b111) errs++;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    logic [DW-1:0] rd;
    int ns, nst, nh, errs, first_st;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 / R7 reset state
    for (int a = 0; a < NR; a++) begin
      cfg_read(a, r);
      chk(r == 0, "R12 region word reset", int'(r), 0);
    end
    cfg_read(3, r);
    chk(r == 32'h10, "R7 polarity resets to 1", int'(r), 16);
    cfg_read(4, r);
    chk(r == 0, "R12 status reset", int'(r), 0);
    chk(mem_cs_n == 3'b111 && mem_oe_n && mem_we_n && !req_ack && !irq,
        "R12 outputs idle", int'({mem_cs_n, mem_oe_n, mem_we_n, req_ack, irq}), 7'b1111100);

    // R1 R2 R9 R10 timing sweep, wait inactive
    for (int dir = 0; dir < 2; dir++)
      for (int s = 0; s < 4; s++)
        for (int t = 0; t < 4; t++)
          for (int h = 0; h < 3; h++) begin
            int rg = (s + t + h) % NR;
            logic [AW-1:0] adr = AW'(s * 16 + t * 4 + h + dir * 64);
            if (dir == 1) cfg_write(rg, rgn_word(15 - s, 14 - t, 13 - h, s, t, h, 1'b0));
            else          cfg_write(rg, rgn_word(s, t, h, 15 - s, 14 - t, 13 - h, 1'b0));
            run_acc(dir[0], rg, adr, 2'(s), {adr, ~adr}, 0, 1'b0, ns, nst, nh, rd, errs);
            chk(ns == s + 1, "R1 setup length", ns, s + 1);
            chk(nst == t + 1, "R1 strobe length", nst, t + 1);
            chk(nh == h + 1, "R1 hold length", nh, h + 1);
            chk(errs == 0, "R2 R9 R10 select/stability/ack", errs, 0);
            if (dir == 0) chk(rd == mem_fn(adr), "R10 read data", int'(rd), int'(mem_fn(adr)));
          end

    // R3 stretch disabled: wait active is ignored
    cfg_write(3, wcfg_word(2, 1'b1, 1'b0));
    mem_wait = 1'b1; settle(3);
    cfg_write(0, rgn_word(3, 3, 0, 3, 3, 0, 1'b0));
    run_acc(1'b0, 0, 8'h11, 2'b11, 16'h0, 0, 1'b0, ns, nst, nh, rd, errs);
    chk(nst == 4, "R3 wait ignored when disabled", nst, 4);
    cfg_read(4, r);
    chk(r == 0, "R3 no timeout when disabled", int'(r), 0);

    // R4 threshold: 4 cycles ignored, 5 cycles recognised (limit 2)
    cfg_write(1, rgn_word(1, 1, 0, 1, 1, 0, 1'b1));
    run_acc(1'b1, 1, 8'h22, 2'b01, 16'hBEEF, 0, 1'b0, ns, nst, nh, rd, errs);
    chk(nst == 2, "R4 setup+strobe=4 ignores wait", nst, 2);
    cfg_write(1, rgn_word(2, 1, 0, 2, 1, 0, 1'b1));
    run_acc(1'b1, 1, 8'h23, 2'b10, 16'h1234, 0, 1'b0, ns, nst, nh, rd, errs);
    chk(nst == 2 + 2 + 1, "R4 setup+strobe=5 honours wait", nst, 5);
    chk(errs == 0, "R4 access integrity", errs, 0);
    cfg_write(4, 32'h1);

    // R6 R8 timeout sweep over limit and strobe length
    for (int m = 0; m < 4; m++)
      for (int t = 1; t < 4; t += 2) begin
        cfg_write(3, wcfg_word(m, 1'b1, 1'b1));
        cfg_write(2, rgn_word(2, t, 0, 2, t, 0, 1'b1));
        run_acc(1'b0, 2, AW'(m * 8 + t), 2'b11, 16'h0, 0, 1'b0, ns, nst, nh, rd, errs);
        chk(nst == t + 1 + m + 1, "R6 timed-out strobe length", nst, t + m + 2);
        chk(rd == mem_fn(AW'(m * 8 + t)), "R10 read data after timeout", int'(rd),
            int'(mem_fn(AW'(m * 8 + t))));
        settle(3);
        cfg_read(4, r);
        chk(r == 1, "R6 timeout flag set", int'(r), 1);
        chk(irq == 1'b1, "R8 irq with enable", int'(irq), 1);
        cfg_write(4, 32'h1);
        settle(2);
        cfg_read(4, r);
        chk(r == 0, "R8 write-one clears flag", int'(r), 0);
        chk(irq == 1'b0, "R8 irq drops after clear", int'(irq), 0);
      end

    // R8 interrupt disabled: flag set, irq low
    cfg_write(3, wcfg_word(1, 1'b1, 1'b0));
    run_acc(1'b0, 2, 8'h44, 2'b11, 16'h0, 0, 1'b0, ns, nst, nh, rd, errs);
    settle(3);
    cfg_read(4, r);
    chk(r == 1 && irq == 1'b0, "R8 irq masked by enable", int'(irq), 0);
    cfg_write(4, 32'h1);

    // R11 back-to-back timed-out accesses have equal length
    cfg_write(3, wcfg_word(3, 1'b1, 1'b0));
    cfg_write(2, rgn_word(2, 2, 1, 2, 2, 1, 1'b1));
    run_acc(1'b0, 2, 8'h50, 2'b11, 16'h0, 0, 1'b0, ns, nst, nh, rd, errs);
    first_st = nst;
    run_acc(1'b0, 2, 8'h51, 2'b11, 16'h0, 0, 1'b0, ns, nst, nh, rd, errs);
    chk(nst == first_st && nst == 3 + 4, "R11 counter restarts per access", nst, 7);
    cfg_write(4, 32'h1);

    // R5 release sweep: limit 10, strobe 3 cycles, release at K
    cfg_write(3, wcfg_word(10, 1'b1, 1'b0));
    cfg_write(0, rgn_word(2, 2, 0, 2, 2, 0, 1'b1));
    for (int k = 3; k <= 3 + 10 - 1; k += 2) begin
      mem_wait = 1'b1; settle(3);
      run_acc(1'b1, 0, AW'(k), 2'b01, 16'(k * 3), k, 1'b0, ns, nst, nh, rd, errs);
      chk(nst == k + 3, "R5 strobe ends 3 cycles after release", nst, k + 3);
      chk(errs == 0, "R5 access integrity", errs, 0);
      cfg_read(4, r);
      chk(r == 0, "R5 release sets no timeout", int'(r), 0);
    end

    // R7 polarity 0: low is active, high is inactive
    cfg_write(3, wcfg_word(1, 1'b0, 1'b0));
    mem_wait = 1'b0; settle(3);
    run_acc(1'b0, 0, 8'h70, 2'b11, 16'h0, 0, 1'b1, ns, nst, nh, rd, errs);
    chk(nst == 3 + 2, "R7 low wait stretches at polarity 0", nst, 5);
    cfg_write(4, 32'h1);
    mem_wait = 1'b1; settle(3);
    run_acc(1'b0, 0, 8'h71, 2'b11, 16'h0, 0, 1'b1, ns, nst, nh, rd, errs);
    chk(nst == 3, "R7 high wait ignored at polarity 0", nst, 3);
    cfg_read(4, r);
    chk(r == 0, "R7 no timeout when inactive", int'(r), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule